// File: doc/BRIEF.md
# Fused Multiply-Add NaN Operand Selector

This block settles, for a fused multiply-add of the form (a*b)+c, which input NaN the result must carry, or whether a freshly generated default NaN is returned instead. It also reports when the invalid-operation condition arises because the product is infinity multiplied by zero. Each operand arrives already classified as an ordinary value, a quiet NaN or a signalling NaN. A separate flag marks the infinity-times-zero product. One bit states which signalling convention is active, and a two-bit policy input chooses among four propagation rule sets.

The result is registered. The selector and the invalid flag that appear after a rising edge belong to the inputs sampled at that edge. The surrounding datapath uses the selector to route the chosen operand, which it quietens if needed, or to substitute its default NaN. The datapath also ORs in invalid for any signalling operand, because this block reports invalid only for the infinity-times-zero cases.

Top module: `fmanan_select`

## Requirements
- R1: While `rst_n` is low, `pick` is 0 and `raise_invalid` is 0.
- R2: `pick` and `raise_invalid` change only at a rising clock edge and reflect the inputs sampled at that edge. Class codes are 2'b00 ordinary, 2'b01 quiet NaN and 2'b10 signalling NaN. `pick` codes are 0 = a, 1 = b, 2 = c and 3 = default NaN.
- R3: Policy 1 with `inf_times_zero` set and c a quiet NaN gives `pick` = 3 and `raise_invalid` = 1.
- R4: Otherwise, policy 1 takes the first match in this list: signalling c, signalling a, signalling b, quiet c, quiet a. If none matches, it gives b.
- R5: Policy 2 with `sig_msb_set` = 1 and `inf_times_zero` set gives `pick` = 3 and `raise_invalid` = 1.
- R6: Otherwise, policy 2 with `sig_msb_set` = 1 looks for a signalling NaN in operand order a, b, c. It then looks for a quiet NaN in order a, b. If neither is found, it gives c.
- R7: Policy 2 with `sig_msb_set` = 0 and `inf_times_zero` set gives `pick` = 2 and `raise_invalid` = 1.
- R8: Otherwise, policy 2 with `sig_msb_set` = 0 looks for a signalling NaN in order c, a, b. It then looks for a quiet NaN in the same order. If neither is found, it gives b.
- R9: Policy 3 with `inf_times_zero` set gives `pick` = 2 and `raise_invalid` = 1. Otherwise it gives a if a is any NaN, else c if c is any NaN, else b.
- R10: Policy 0 gives a if a is any NaN, else b if b is any NaN, else c. It never raises invalid, whatever `inf_times_zero` is.
- R11: `raise_invalid` is 1 only in the cases of R3, R5, R7 and R9. This includes policy 1 with `inf_times_zero` set while c is not a quiet NaN, where it stays 0.
- R12: The unused class code 2'b11 counts as an ordinary, non-NaN operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_a | input | 2 | Class of multiplicand a |
| cls_b | input | 2 | Class of multiplier b |
| cls_c | input | 2 | Class of addend c |
| inf_times_zero | input | 1 | Product is infinity times zero |
| sig_msb_set | input | 1 | 1: a set fraction MSB marks a signalling NaN |
| policy | input | 2 | Rule set: 0 plain, 1 addend-first, 2 convention-dependent, 3 a-then-c |
| pick | output | 2 | Selected source: 0 a, 1 b, 2 c, 3 default NaN |
| raise_invalid | output | 1 | Invalid from the infinity-times-zero case |

## Verification
The hardest situations to reach are those where several NaNs compete and the order within one class decides the result. Examples are signalling b against quiet c under policy 1, and quiet b against quiet c under policy 2 for each convention. A further case is the infinity-times-zero flag together with a signalling c under policy 1, which must not raise invalid. A directed table puts each of these collisions on the inputs under every policy and convention. A long random run then covers all 64 class triples against every flag combination, and also drives the unused class code.

// File: rtl/fmanan_pkg.sv
package fmanan_pkg;

    localparam int CLS_W = 2;
    localparam int POL_W = 2;
    localparam int SEL_W = 2;
    localparam int N_OPS = 3;

    localparam logic [CLS_W-1:0] CLS_QUIET = 2'b01;
    localparam logic [CLS_W-1:0] CLS_SIG   = 2'b10;

    typedef enum logic [SEL_W-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_DFLT = 2'd3
    } sel_e;

    typedef enum logic [POL_W-1:0] {
        POL_PLAIN   = 2'd0,
        POL_ADDEND  = 2'd1,
        POL_CONVDEP = 2'd2,
        POL_ATHENC  = 2'd3
    } pol_e;

    typedef struct packed {
        logic quiet;
        logic sig;
    } opflag_s;

    typedef struct packed {
        sel_e pick;
        logic inv;
    } verdict_s;

endpackage

// File: rtl/fmanan_cls_decode.sv
module fmanan_cls_decode
    import fmanan_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output opflag_s          flags
);
    always_comb begin
        flags.quiet = (cls == CLS_QUIET);
        flags.sig   = (cls == CLS_SIG);
    end
endmodule

// File: rtl/fmanan_policy.sv
module fmanan_policy
    import fmanan_pkg::*;
(
    input  opflag_s          fa,
    input  opflag_s          fb,
    input  opflag_s          fc,
    input  logic             iz,
    input  logic             msb_sig,
    input  logic [POL_W-1:0] pol,
    output verdict_s         verdict
);
    logic nan_a, nan_b, nan_c;

    always_comb begin
        nan_a = fa.quiet | fa.sig;
        nan_b = fb.quiet | fb.sig;
        nan_c = fc.quiet | fc.sig;
        verdict.inv  = 1'b0;
        verdict.pick = SEL_C;
        unique case (pol_e'(pol))
            POL_ADDEND: begin
                if (iz && fc.quiet) begin
                    verdict.inv  = 1'b1;
                    verdict.pick = SEL_DFLT;
                end
                else if (fc.sig)   verdict.pick = SEL_C;
                else if (fa.sig)   verdict.pick = SEL_A;
                else if (fb.sig)   verdict.pick = SEL_B;
                else if (fc.quiet) verdict.pick = SEL_C;
                else if (fa.quiet) verdict.pick = SEL_A;
                else               verdict.pick = SEL_B;
            end
            POL_CONVDEP: begin
                if (msb_sig) begin
                    if (iz) begin
                        verdict.inv  = 1'b1;
                        verdict.pick = SEL_DFLT;
                    end
                    else if (fa.sig)   verdict.pick = SEL_A;
                    else if (fb.sig)   verdict.pick = SEL_B;
                    else if (fc.sig)   verdict.pick = SEL_C;
                    else if (fa.quiet) verdict.pick = SEL_A;
                    else if (fb.quiet) verdict.pick = SEL_B;
                    else               verdict.pick = SEL_C;
                end
                else begin
                    if (iz) begin
                        verdict.inv  = 1'b1;
                        verdict.pick = SEL_C;
                    end
                    else if (fc.sig)   verdict.pick = SEL_C;
                    else if (fa.sig)   verdict.pick = SEL_A;
                    else if (fb.sig)   verdict.pick = SEL_B;
                    else if (fc.quiet) verdict.pick = SEL_C;
                    else if (fa.quiet) verdict.pick = SEL_A;
                    else               verdict.pick = SEL_B;
                end
            end
            POL_ATHENC: begin
                if (iz) begin
                    verdict.inv  = 1'b1;
                    verdict.pick = SEL_C;
                end
                else if (nan_a) verdict.pick = SEL_A;
                else if (nan_c) verdict.pick = SEL_C;
                else            verdict.pick = SEL_B;
            end
            default: begin
                if (nan_a)      verdict.pick = SEL_A;
                else if (nan_b) verdict.pick = SEL_B;
                else            verdict.pick = SEL_C;
            end
        endcase
    end
endmodule

// File: rtl/fmanan_select.sv
module fmanan_select
    import fmanan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cls_a,
    input  logic [1:0]       cls_b,
    input  logic [1:0]       cls_c,
    input  logic             inf_times_zero,
    input  logic             sig_msb_set,
    input  logic [1:0]       policy,
    output logic [1:0]       pick,
    output logic             raise_invalid
);
    logic [N_OPS-1:0][CLS_W-1:0] cls_vec;
    opflag_s [N_OPS-1:0]         flg;
    verdict_s                    out_d, out_q;

    assign cls_vec = {cls_c, cls_b, cls_a};

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_dec
        fmanan_cls_decode u_dec (
            .cls   (cls_vec[gi]),
            .flags (flg[gi])
        );
    end

    fmanan_policy u_pol (
        .fa      (flg[0]),
        .fb      (flg[1]),
        .fc      (flg[2]),
        .iz      (inf_times_zero),
        .msb_sig (sig_msb_set),
        .pol     (policy),
        .verdict (out_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '{pick: SEL_A, inv: 1'b0};
        else        out_q <= out_d;
    end

    assign pick          = out_q.pick;
    assign raise_invalid = out_q.inv;

    // Invalid is only ever the infinity-times-zero case
    assert_inv_needs_iz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        raise_invalid |-> $past(inf_times_zero));

    // The default NaN always comes with invalid (R3, R5)
    assert_dflt_with_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == 2'd3) |-> (raise_invalid && ($past(policy) == 2'd1 || $past(policy) == 2'd2)));

    assert_plain_noinv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(policy) == 2'd0) |-> !raise_invalid);

    assert_athenc_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(policy) == 2'd3 && !$past(inf_times_zero)
         && ($past(cls_a) == 2'b01 || $past(cls_a) == 2'b10)) |-> (pick == 2'd0));

    assert_addend_sigc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(policy) == 2'd1 && $past(cls_c) == 2'b10) |-> (pick == 2'd2 && !raise_invalid));

    assert_resv_not_nan_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(policy) == 2'd0 && $past(cls_a) == 2'b11) |-> (pick != 2'd0));

endmodule

// File: tb/test_fmanan_select.sv
module test_fmanan_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cls_a = '0, cls_b = '0, cls_c = '0, policy = '0;
    logic       inf_times_zero = 1'b0, sig_msb_set = 1'b0;
    logic [1:0] pick;
    logic       raise_invalid;

    int checks = 0;
    int errors = 0;
    int exp_sel = 0;
    int exp_inv = 0;
    string exp_tag = "R2";

    always #4 clk = ~clk;

    fmanan_select i_fmanan_select (
        .clk(clk), .rst_n(rst_n), .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
        .inf_times_zero(inf_times_zero), .sig_msb_set(sig_msb_set), .policy(policy),
        .pick(pick), .raise_invalid(raise_invalid));

    // Step encoding: kind*4 + operand; kind 1 = signalling, 2 = quiet, 3 = any NaN
    function automatic void model(input int ca, input int cb, input int cc, input int iz,
                                  input int sm, input int pol,
                                  output int sel, output int inv, output string tag);
        int cl[3];
        int steps[$];
        int fallback;
        bit hit;
        cl[0] = ca; cl[1] = cb; cl[2] = cc;
        inv = 0; sel = -1; fallback = 2;
        if (pol == 0) begin
            tag = "R10"; steps = '{12, 13}; fallback = 2;
        end else if (pol == 1) begin
            if (iz != 0 && cc == 1) begin tag = "R3"; sel = 3; inv = 1; end
            else begin tag = "R4"; steps = '{6, 4, 5, 10, 8}; fallback = 1; end
        end else if (pol == 2 && sm != 0) begin
            if (iz != 0) begin tag = "R5"; sel = 3; inv = 1; end
            else begin tag = "R6"; steps = '{4, 5, 6, 8, 9}; fallback = 2; end
        end else if (pol == 2) begin
            if (iz != 0) begin tag = "R7"; sel = 2; inv = 1; end
            else begin tag = "R8"; steps = '{6, 4, 5, 10, 8}; fallback = 1; end
        end else begin
            tag = "R9";
            if (iz != 0) begin sel = 2; inv = 1; end
            else begin steps = '{12, 14}; fallback = 1; end
        end
        if (sel < 0) begin
            hit = 0;
            foreach (steps[k]) begin
                int kind = steps[k] / 4;
                int op = steps[k] % 4;
                bit m = (kind == 1) ? (cl[op] == 2) : (kind == 2) ? (cl[op] == 1)
                        : (cl[op] == 1 || cl[op] == 2);
                if (!hit && m) begin sel = op; hit = 1; end
            end
            if (!hit) sel = fallback;
        end
        if (ca == 3 || cb == 3 || cc == 3) tag = "R12";
        if (iz != 0 && inv == 0) tag = "R11";
    endfunction

    task automatic check(input int s, input int v, input string tag);
        checks++;
        if (int'(pick) != s || int'(raise_invalid) != v) begin
            errors++;
            $display("FAIL %s pick=%0d inv=%0d expected pick=%0d inv=%0d", tag,
                     pick, raise_invalid, s, v);
        end
    endtask

    // Apply at a falling edge; the result shows after the next rising edge
    task automatic apply(input int ca, input int cb, input int cc, input int iz,
                         input int sm, input int pol);
        cls_a = 2'(ca); cls_b = 2'(cb); cls_c = 2'(cc);
        inf_times_zero = 1'(iz); sig_msb_set = 1'(sm); policy = 2'(pol);
        #1;
        check(exp_sel, exp_inv, "R2");   // output must not move before the edge
        model(ca, cb, cc, iz, sm, pol, exp_sel, exp_inv, exp_tag);
        @(negedge clk);
        check(exp_sel, exp_inv, exp_tag);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cls_a = 2'b10; policy = 2'd1; inf_times_zero = 1'b1; cls_c = 2'b01;
        @(negedge clk);
        check(0, 0, "R1");
        @(negedge clk);
        check(0, 0, "R1");
        rst_n = 1'b1;
        exp_sel = 0; exp_inv = 0;
        // Directed collisions
        apply(0, 1, 2, 1, 0, 1);  // R4: iz with signalling c, no invalid (R11)
        apply(0, 2, 1, 0, 0, 1);  // R4: signalling b beats quiet c
        apply(1, 0, 1, 1, 0, 1);  // R3
        apply(1, 1, 1, 0, 0, 1);  // R4: quiet c first
        apply(0, 0, 0, 0, 0, 1);  // R4: fallback b
        apply(1, 1, 2, 0, 1, 2);  // R6: signalling c beats quiet a
        apply(0, 1, 1, 0, 1, 2);  // R6: quiet b beats quiet c
        apply(0, 0, 0, 1, 1, 2);  // R5
        apply(0, 1, 1, 0, 0, 2);  // R8: quiet c beats quiet b
        apply(2, 2, 0, 0, 0, 2);  // R8: signalling a
        apply(0, 0, 0, 1, 0, 2);  // R7
        apply(0, 2, 1, 0, 0, 3);  // R9: c before b
        apply(1, 2, 2, 1, 0, 3);  // R9 with iz
        apply(0, 1, 2, 1, 1, 0);  // R10 iz ignored
        apply(3, 3, 1, 0, 0, 0);  // R12
        apply(3, 3, 3, 0, 0, 3);  // R12
        for (int n = 0; n < 4000; n++) begin
            apply($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule